// File: doc/BRIEF.md
# Flash Command Decoder and Operation Sequencer

This block sits on the device side of a small parallel NOR-style flash model. It takes bus write cycles that carry a command byte, an address and data. It decodes two-cycle program and erase sequences and runs a timed word program or a timed block erase on an internal array. It keeps a status register with a ready flag, a suspended flag and three sticky error flags. Each read is answered either from the array or from the status register. The answer depends on the current read mode, on whether an operation is running, and on whether an erase is suspended with the read landing inside the block being erased.

The array is split into `2**BLK_BITS` blocks of `2**WORD_BITS` words. Block `BOOT_BLK` is protected: it can only be programmed or erased while `boot_unlock` is high. Operation lengths and the suspend latency are parameters counted in clock cycles. A running erase can be suspended so that other blocks can be read, and then resumed.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the error and suspend flags are clear, no operation runs and reads return array data. A read-status command (70h) then returns 80h. Array contents survive reset.
- R2: A write of 20h followed by a write of D0h erases the block selected by the second cycle's address, so every word of that block reads FFh afterwards. The address of the 20h cycle is not used.
- R3: A write of 40h or 10h followed by one more write cycle stores that cycle's data byte at that cycle's address.
- R4: Status byte layout: bit 7 is ready, bit 6 is erase-suspended, bit 5 is erase error, bit 4 is program error, bit 3 is voltage error, and bits 2:0 are 0. Read data appears one cycle after `rd_en`, with `rd_valid` high. While an operation runs, every read returns status with bit 7 at 0. After completion, reads stay in status mode until FFh is written.
- R5: Any byte other than D0h after 20h sets bits 5 and 4, selects status mode and erases nothing.
- R6: Bits 5, 4 and 3 stay set through later commands and completions. Only 50h clears them.
- R7: If `vpp_ok` is low on the second cycle of a program or erase, bit 3 is set together with bit 4 (program) or bit 5 (erase), and nothing is written. While bit 3 is set, a program or erase sequence sets bit 4 or bit 5 respectively and does not start.
- R8: While an erase or program runs, every command except erase suspend (B0h during an erase) has no effect.
- R9: A program or erase aimed at block `BOOT_BLK` while `boot_unlock` is low sets bit 4 or bit 5 respectively and leaves the block unchanged. With `boot_unlock` high, the operation proceeds.
- R10: B0h during an erase sets bits 6 and 7 after `SUSP_LAT` cycles. While suspended, only FFh (array mode), 70h (status mode) and D0h (resume) are accepted. After resume, the erase runs to completion.
- R11: While suspended in array mode, reads outside the erased block return array data and reads inside it return status.
- R12: D0h written after B0h but before bit 6 has been set cancels the suspend. The erase then continues without bit 6 ever being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | BLK_BITS+WORD_BITS | Write cycle address |
| wr_data | input | DATA_W | Command byte or program data |
| rd_en | input | 1 | Read request |
| rd_addr | input | BLK_BITS+WORD_BITS | Read address |
| vpp_ok | input | 1 | Program voltage valid |
| boot_unlock | input | 1 | Boot block unlock |
| rd_data | output | DATA_W | Array word or status byte |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
A wrong decoder or engine state shows up on the first read after the offending write cycle. It appears either as a status byte where array data was due, or as a status byte with a wrong ready, suspend or error bit. Effects on the array, such as a missed erase or a program that should have been blocked, are exposed by an array-mode read of the affected word as soon as the device is back in array mode. Suspend timing is seen through bit 6 within the suspend latency. The cancelled-suspend case is seen through a status read with bit 6 still clear while the erase is running.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_PROG, ENG_ERASE, ENG_SUSP} eng_state_t;
  typedef enum logic [1:0] {CMD_IDLE, CMD_PGM_SETUP, CMD_ERS_SETUP} cmd_state_t;

  localparam logic [7:0] OPC_ERS_SETUP = 8'h20;
  localparam logic [7:0] OPC_CONFIRM   = 8'hD0;
  localparam logic [7:0] OPC_PGM_A     = 8'h40;
  localparam logic [7:0] OPC_PGM_B     = 8'h10;
  localparam logic [7:0] OPC_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] OPC_RD_STAT   = 8'h70;
  localparam logic [7:0] OPC_CLR_STAT  = 8'h50;
  localparam logic [7:0] OPC_SUSPEND   = 8'hB0;

  // sticky error vector index: {erase, program, voltage}
  localparam int ERR_VPP = 0;
  localparam int ERR_PGM = 1;
  localparam int ERR_ERS = 2;
endpackage

// File: rtl/flash_status.sv
module flash_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_vpp,
  input  logic       set_pgm,
  input  logic       set_ers,
  input  logic       clr,
  output logic [2:0] err
);
  import flash_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= '0;
    end else if (clr) begin
      err <= '0;
    end else begin
      err[ERR_VPP] <= err[ERR_VPP] | set_vpp;
      err[ERR_PGM] <= err[ERR_PGM] | set_pgm;
      err[ERR_ERS] <= err[ERR_ERS] | set_ers;
    end
  end
endmodule

// File: rtl/flash_engine.sv
module flash_engine #(
  parameter int BLK_BITS   = 2,
  parameter int WORD_BITS  = 4,
  parameter int DATA_W     = 8,
  parameter int PROG_CYC   = 4,
  parameter int ERASE_WAIT = 6,
  parameter int SUSP_LAT   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_prog,
  input  logic                          start_erase,
  input  logic [BLK_BITS+WORD_BITS-1:0] addr,
  input  logic [DATA_W-1:0]             data,
  input  logic                          susp_req,
  input  logic                          resume_req,
  output logic                          running,
  output logic                          erasing,
  output logic                          suspended,
  output logic                          susp_pend,
  output logic [BLK_BITS-1:0]           erase_blk,
  output logic                          mem_we,
  output logic [BLK_BITS+WORD_BITS-1:0] mem_addr,
  output logic [DATA_W-1:0]             mem_wdata
);
  import flash_pkg::*;

  localparam int AW   = BLK_BITS + WORD_BITS;
  localparam int MAX1 = (PROG_CYC > ERASE_WAIT) ? PROG_CYC : ERASE_WAIT;
  localparam int MAXC = (MAX1 > SUSP_LAT) ? MAX1 : SUSP_LAT;
  localparam int CW   = $clog2(MAXC + 1);

  eng_state_t           st;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        scnt;
  logic [WORD_BITS-1:0] idx;
  logic [AW-1:0]        paddr;
  logic [DATA_W-1:0]    pdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ENG_IDLE;
      cnt       <= '0;
      scnt      <= '0;
      idx       <= '0;
      paddr     <= '0;
      pdata     <= '0;
      erase_blk <= '0;
      susp_pend <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (start_prog) begin
            st    <= ENG_PROG;
            cnt   <= CW'(PROG_CYC - 1);
            paddr <= addr;
            pdata <= data;
          end else if (start_erase) begin
            st        <= ENG_ERASE;
            cnt       <= CW'(ERASE_WAIT - 1);
            idx       <= '0;
            erase_blk <= addr[AW-1:WORD_BITS];
            susp_pend <= 1'b0;
          end
        end
        ENG_PROG: begin
          if (cnt == '0) st <= ENG_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        ENG_ERASE: begin
          if (susp_req && !susp_pend) begin
            susp_pend <= 1'b1;
            scnt      <= CW'(SUSP_LAT - 1);
          end else if (susp_pend && resume_req) begin
            susp_pend <= 1'b0;
          end else if (susp_pend) begin
            if (scnt == '0) begin
              st        <= ENG_SUSP;
              susp_pend <= 1'b0;
            end else begin
              scnt <= scnt - 1'b1;
            end
          end
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            idx <= idx + 1'b1;
            if (idx == {WORD_BITS{1'b1}}) begin
              st        <= ENG_IDLE;
              susp_pend <= 1'b0;
            end
          end
        end
        ENG_SUSP: begin
          if (resume_req) st <= ENG_ERASE;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign running   = (st == ENG_PROG) || (st == ENG_ERASE);
  assign erasing   = (st == ENG_ERASE);
  assign suspended = (st == ENG_SUSP);
  assign mem_we    = running && (cnt == '0);
  assign mem_addr  = (st == ENG_PROG) ? paddr : {erase_blk, idx};
  assign mem_wdata = (st == ENG_PROG) ? pdata : {DATA_W{1'b1}};
endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int AW     = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  input  logic              use_status,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] stat_q;
  logic              sel_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) begin
      arr_q  <= mem[raddr];
      stat_q <= status;
      sel_q  <= use_status;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= re;
  end

  assign rd_data = sel_q ? stat_q : arr_q;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int BLK_BITS   = 2,
  parameter int WORD_BITS  = 4,
  parameter int DATA_W     = 8,
  parameter int BOOT_BLK   = 0,
  parameter int PROG_CYC   = 4,
  parameter int ERASE_WAIT = 6,
  parameter int SUSP_LAT   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [BLK_BITS+WORD_BITS-1:0] wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_en,
  input  logic [BLK_BITS+WORD_BITS-1:0] rd_addr,
  input  logic                          vpp_ok,
  input  logic                          boot_unlock,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid
);
  import flash_pkg::*;

  localparam int AW = BLK_BITS + WORD_BITS;
  localparam logic [BLK_BITS-1:0] BOOT_ID = BLK_BITS'(BOOT_BLK);

  cmd_state_t cst, cst_n;
  logic       stat_mode, mode_n;

  logic start_prog, start_erase, susp_req, resume_req;
  logic set_vpp, set_pgm, set_ers, clr_err;
  logic running, erasing, suspended, susp_pend;
  logic [BLK_BITS-1:0] erase_blk;
  logic                mem_we;
  logic [AW-1:0]       mem_addr;
  logic [DATA_W-1:0]   mem_wdata;
  logic [2:0]          err;
  logic [DATA_W-1:0]   stat_word;
  logic                use_status;
  logic [7:0]          cmd;
  logic                wr_boot;

  assign cmd     = wr_data[7:0];
  assign wr_boot = (wr_addr[AW-1:WORD_BITS] == BOOT_ID);

  always_comb begin
    cst_n       = cst;
    mode_n      = stat_mode;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    susp_req    = 1'b0;
    resume_req  = 1'b0;
    set_vpp     = 1'b0;
    set_pgm     = 1'b0;
    set_ers     = 1'b0;
    clr_err     = 1'b0;
    if (wr_en) begin
      if (running) begin
        if (erasing && !susp_pend && cmd == OPC_SUSPEND) susp_req = 1'b1;
        if (erasing && susp_pend && cmd == OPC_CONFIRM)  resume_req = 1'b1;
      end else if (suspended) begin
        case (cmd)
          OPC_RD_ARRAY: mode_n = 1'b0;
          OPC_RD_STAT:  mode_n = 1'b1;
          OPC_CONFIRM: begin
            resume_req = 1'b1;
            mode_n     = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (cst)
          CMD_ERS_SETUP: begin
            cst_n  = CMD_IDLE;
            mode_n = 1'b1;
            if (cmd != OPC_CONFIRM) begin
              set_pgm = 1'b1;
              set_ers = 1'b1;
            end else if (err[ERR_VPP]) begin
              set_ers = 1'b1;
            end else if (!vpp_ok) begin
              set_vpp = 1'b1;
              set_ers = 1'b1;
            end else if (wr_boot && !boot_unlock) begin
              set_ers = 1'b1;
            end else begin
              start_erase = 1'b1;
            end
          end
          CMD_PGM_SETUP: begin
            cst_n  = CMD_IDLE;
            mode_n = 1'b1;
            if (err[ERR_VPP]) begin
              set_pgm = 1'b1;
            end else if (!vpp_ok) begin
              set_vpp = 1'b1;
              set_pgm = 1'b1;
            end else if (wr_boot && !boot_unlock) begin
              set_pgm = 1'b1;
            end else begin
              start_prog = 1'b1;
            end
          end
          default: begin
            case (cmd)
              OPC_ERS_SETUP:        begin cst_n = CMD_ERS_SETUP; mode_n = 1'b1; end
              OPC_PGM_A, OPC_PGM_B: begin cst_n = CMD_PGM_SETUP; mode_n = 1'b1; end
              OPC_RD_STAT:          mode_n = 1'b1;
              OPC_RD_ARRAY:         mode_n = 1'b0;
              OPC_CLR_STAT:         clr_err = 1'b1;
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cst       <= CMD_IDLE;
      stat_mode <= 1'b0;
    end else begin
      cst       <= cst_n;
      stat_mode <= mode_n;
    end
  end

  assign stat_word  = DATA_W'({!running, suspended, err[ERR_ERS], err[ERR_PGM], err[ERR_VPP], 3'b000});
  assign use_status = stat_mode || running ||
                      (suspended && rd_addr[AW-1:WORD_BITS] == erase_blk);

  flash_status u_status (
    .clk(clk), .rst(rst),
    .set_vpp(set_vpp), .set_pgm(set_pgm), .set_ers(set_ers), .clr(clr_err),
    .err(err)
  );

  flash_engine #(
    .BLK_BITS(BLK_BITS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .ERASE_WAIT(ERASE_WAIT), .SUSP_LAT(SUSP_LAT)
  ) u_engine (
    .clk(clk), .rst(rst),
    .start_prog(start_prog), .start_erase(start_erase),
    .addr(wr_addr), .data(wr_data),
    .susp_req(susp_req), .resume_req(resume_req),
    .running(running), .erasing(erasing), .suspended(suspended),
    .susp_pend(susp_pend), .erase_blk(erase_blk),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  flash_store #(.AW(AW), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .re(rd_en), .raddr(rd_addr),
    .use_status(use_status), .status(stat_word),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int BLK_BITS = 2,
  parameter int BOOT_BLK = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic                rd_valid,
  input logic                wr_en,
  input logic                boot_unlock,
  input logic                start_prog,
  input logic                start_erase,
  input logic                running,
  input logic                suspended,
  input logic                mem_we,
  input logic [BLK_BITS-1:0] start_blk,
  input logic [2:0]          err,
  input logic                clr_err
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid); // R4
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid); // R4
  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (rst) (|($past(err) & ~err)) |-> $past(clr_err)); // R6
  AST_VPP_BLOCKS: assert property (@(posedge clk) disable iff (rst) (start_prog || start_erase) |-> !err[0]); // R7
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst) (running || suspended) |-> !(start_prog || start_erase)); // R8
  AST_BOOT_LOCK: assert property (@(posedge clk) disable iff (rst) (start_erase && start_blk == BLK_BITS'(BOOT_BLK)) |-> boot_unlock); // R9
  AST_SUSP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) suspended |-> !mem_we); // R10
  AST_ONE_START: assert property (@(posedge clk) disable iff (rst) $onehot0({start_prog, start_erase})); // R2
  AST_START_NEEDS_WR: assert property (@(posedge clk) disable iff (rst) (start_prog || start_erase) |-> wr_en); // R3
endmodule

bind flash_cmd_fsm flash_cmd_chk #(.BLK_BITS(BLK_BITS), .BOOT_BLK(BOOT_BLK)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid), .wr_en(wr_en),
  .boot_unlock(boot_unlock), .start_prog(start_prog), .start_erase(start_erase),
  .running(running), .suspended(suspended), .mem_we(mem_we),
  .start_blk(wr_addr[BLK_BITS+WORD_BITS-1:WORD_BITS]), .err(err), .clr_err(clr_err)
);

// File: tb/sim_flash_cmd_fsm.sv
`timescale 1ns/1ps
module sim_flash_cmd_fsm;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NV = 63;

  // vector: [31:30] op (01 write, 10 read+check, 11 poll ready+check)
  //         [29] vpp_ok [28] boot_unlock [27:24] requirement number
  //         [23:16] address [15:8] write data [7:0] expected read
  localparam logic [31:0] VEC [NV] = '{
    32'h6_2_10_20_00, 32'h6_2_15_D0_00, 32'hE_2_15_00_80,               // R2 erase block 1
    32'h6_2_00_FF_00, 32'hA_2_10_00_FF, 32'hA_2_1F_00_FF,
    32'h6_3_00_40_00, 32'h6_3_13_5A_00, 32'hE_3_13_00_80,               // R3 program via 40h
    32'h6_3_00_FF_00, 32'hA_3_13_00_5A, 32'hA_3_12_00_FF,
    32'h6_4_00_10_00, 32'h6_4_14_3C_00, 32'hE_4_14_00_80,               // R4 10h, status mode sticks
    32'hA_4_14_00_80, 32'h6_4_00_FF_00, 32'hA_4_14_00_3C,
    32'h6_5_00_20_00, 32'h6_5_10_33_00, 32'hA_5_10_00_B0,               // R5 bad confirm
    32'h6_5_00_FF_00, 32'hA_5_13_00_5A,
    32'h6_6_00_70_00, 32'hA_6_00_00_B0, 32'h6_6_00_50_00, 32'hA_6_00_00_80, // R6 sticky, clear
    32'h4_7_00_20_00, 32'h4_7_10_D0_00, 32'hA_7_10_00_A8,               // R7 voltage low on erase
    32'h6_7_00_40_00, 32'h6_7_11_00_00, 32'hA_7_11_00_B8,               // R7 blocked by SR3
    32'h6_7_00_FF_00, 32'hA_7_11_00_FF,
    32'h6_6_00_70_00, 32'hA_6_00_00_B8, 32'h6_6_00_50_00, 32'hA_6_00_00_80,
    32'h6_7_00_40_00, 32'h4_7_11_00_00, 32'hA_7_11_00_98, 32'h6_6_00_50_00, // R7 voltage low on program
    32'h6_9_00_20_00, 32'h6_9_03_D0_00, 32'hA_9_03_00_A0, 32'h6_9_00_50_00, // R9 boot locked erase
    32'h6_9_00_40_00, 32'h6_9_02_00_00, 32'hA_9_02_00_90, 32'h6_9_00_50_00, // R9 boot locked program
    32'h7_9_00_20_00, 32'h7_9_05_D0_00, 32'hE_9_05_00_80,               // R9 unlocked erase
    32'h6_9_00_FF_00, 32'hA_9_00_00_FF, 32'hA_9_0F_00_FF,
    32'h6_2_00_20_00, 32'h6_2_20_D0_00, 32'hE_2_20_00_80,               // R2 erase block 2
    32'h6_3_00_40_00, 32'h6_3_21_77_00, 32'hE_3_21_00_80                // R3 word in block 2
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          vpp_ok = 1'b1;
  logic          boot_unlock = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_fsm u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .vpp_ok(vpp_ok), .boot_unlock(boot_unlock),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input int req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic v, input logic u);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; vpp_ok = v; boot_unlock = u;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic step(input logic [31:0] v);
    logic [DW-1:0] got;
    int req;
    req = int'(v[27:24]);
    case (v[31:30])
      2'b01: bus_wr(v[16 +: AW], v[15:8], v[29], v[28]);
      2'b10: begin
        bus_rd(v[16 +: AW], got);
        check(req, got, v[7:0]);
      end
      2'b11: begin
        got = '0;
        for (int i = 0; i < 200; i++) begin
          bus_rd(v[16 +: AW], got);
          if (got[7]) break;
        end
        check(req, got, v[7:0]);
      end
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, no read pending
    check(1, {7'b0, rd_valid}, 8'h00);
    step(32'h6_1_00_70_00);
    bus_rd('0, got);
    check(1, got, 8'h80);
    check(4, {7'b0, rd_valid}, 8'h01);  // R4 read valid after one cycle

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // R10 / R11: suspend erase of block 2
    step(32'h6_A_00_20_00); step(32'h6_A_20_D0_00); step(32'h6_A_00_B0_00);
    step(32'hE_A_00_00_C0);
    step(32'h6_B_00_FF_00);
    step(32'hA_B_13_00_5A);          // R11 outside erased block
    step(32'hA_B_21_00_C0);          // R11 inside erased block
    step(32'h6_A_13_40_00);          // R10 program setup ignored while suspended
    step(32'h6_A_13_D0_00);          // R10 resume
    step(32'hE_A_13_00_80);
    step(32'h6_A_00_FF_00);
    step(32'hA_A_21_00_FF);          // R10 erase completed
    step(32'hA_A_13_00_5A);          // R10 word not reprogrammed

    // R12: resume before suspend takes effect
    step(32'h6_3_00_40_00); step(32'h6_3_22_11_00); step(32'hE_3_22_00_80);
    step(32'h6_C_00_20_00); step(32'h6_C_20_D0_00);
    step(32'h6_C_00_B0_00); step(32'h6_C_00_D0_00);
    step(32'hA_C_00_00_00);          // R12 busy, SR6 clear
    step(32'hE_C_00_00_80);
    step(32'h6_C_00_FF_00);
    step(32'hA_C_22_00_FF);

    // R8: commands during erase have no effect
    step(32'h6_8_00_20_00); step(32'h6_8_30_D0_00);
    step(32'h6_8_00_FF_00); step(32'h6_8_00_50_00);
    step(32'hE_8_30_00_80);
    step(32'hA_8_30_00_80);

    // R8: commands during program have no effect
    step(32'h6_8_00_FF_00);
    step(32'h6_8_00_40_00); step(32'h6_8_23_44_00); step(32'h6_8_00_FF_00);
    step(32'hE_8_23_00_80);
    step(32'hA_8_23_00_80);

    // R1: reset clears errors, array read mode, array kept
    step(32'h6_1_00_20_00); step(32'h6_1_10_33_00); step(32'hA_1_10_00_B0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    step(32'hA_1_13_00_5A);
    step(32'h6_1_00_70_00);
    step(32'hA_1_00_00_80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule